// File: doc/BRIEF.md
# Pin I/O controller with both-edge change interrupts

The block gives a processor control over a parameterised number of general-purpose pins (one to thirty-two) through a small word-indexed register bus. Software chooses each pin's direction and drives output values through a data register. A per-bit write mask limits which output bits a data write can change. Reading the same data register returns the current pin levels.

Every pin passes through a two-stage synchroniser. Any rising or falling transition of the synchronised level sets a sticky bit in a change register. Software clears these bits by writing ones to them. The change bits are gated with a per-pin enable register and combined into a single interrupt request for a parent interrupt controller. Only both-edge detection exists. A read-only kind register reports it.

Top module: `pinio_edge_ctrl`

## Requirements
- R1: Register word 0 (byte offset 0x00) is the direction register. A 1 in bit i drives `pin_oe[i]` high and makes pin i an output. A 0 makes pin i an input.
- R2: A read of word 1 (offset 0x04) returns, for each pin, the driven output value when the pin is an output. For an input pin it returns the synchronised pin level. A change at `pin_in` appears in this read after two rising clock edges.
- R3: A write to word 1 changes only those output bits whose bit in the write-mask register (word 4, offset 0x10) is 1. The mask resets to all ones over the implemented pins.
- R4: Word 2 (offset 0x08) is the interrupt enable register and reads back what was written.
- R5: Bit i of the change register (word 3, offset 0x0C) is set by either a rising or a falling transition of pin i. The bit becomes visible after three rising clock edges from the pin change. The pin's direction does not matter.
- R6: Writing a 1 to a change bit clears it, and writing a 0 leaves it unchanged. If a transition is detected in the same cycle as the clearing write, the bit stays set.
- R7: `irq` is high exactly when some pin has both its change bit and its enable bit set.
- R8: Word 5 (offset 0x14) always reads 32'h1, the code for both-edge detection. Writes to it are ignored.
- R9: After reset the direction, output, enable and change registers are zero. Bits at and above NLINES read as zero. Words 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | 32 | Read data of the register at bus_word, same cycle |
| pin_in | input | NLINES | Asynchronous pin levels |
| pin_out | output | NLINES | Output values |
| pin_oe | output | NLINES | Output enables (1 = drive) |
| irq | output | 1 | Combined change interrupt |

## Verification
The hardest case to reach from the ports is a pin transition that is detected in the same cycle as a software clear of the same change bit. The set must win in that cycle. The bench counts the three register stages between `pin_in` and the change register. It changes a pin and issues the clearing write so that the bus write is sampled on the very edge that latches the detected transition. A cycle-accurate reference model then shows whether the bit survived. Masked data writes and falling edges on bits that are already pending are also driven.

// File: rtl/pinio_pkg.sv
package pinio_pkg;
  typedef enum logic [2:0] {
    IDX_DIR   = 3'd0,
    IDX_DATA  = 3'd1,
    IDX_IRQEN = 3'd2,
    IDX_CHG   = 3'd3,
    IDX_WMASK = 3'd4,
    IDX_KIND  = 3'd5
  } reg_idx_e;

  localparam logic [31:0] KIND_BOTH_EDGES = 32'h0000_0001;

  // New value of a sticky register: clears applied first, sets win.
  function automatic logic [31:0] sticky_next(logic [31:0] cur, logic [31:0] set_v,
                                               logic [31:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // Merge write data into old value where mask is one.
  function automatic logic [31:0] masked_merge(logic [31:0] old_v, logic [31:0] new_v,
                                               logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Level seen by software: driven value on outputs, sampled pin on inputs.
  function automatic logic [31:0] pin_view(logic [31:0] drv, logic [31:0] smp,
                                           logic [31:0] dir);
    return (drv & dir) | (smp & ~dir);
  endfunction
endpackage

// File: rtl/pinio_sync_edge.sv
module pinio_sync_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] level,
  output logic [W-1:0] toggled
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign level   = stab_q;
  assign toggled = stab_q ^ prev_q;

  // R5: a toggle pulse means the level differs from the cycle before
  a_r5_toggle_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    (toggled != '0) |-> (level != $past(level)));
endmodule

// File: rtl/pinio_change_latch.sv
module pinio_change_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] pending
);
  import pinio_pkg::*;

  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= W'(sticky_next(32'(pend_q), 32'(set_v), 32'(clr_v)));
  end

  assign pending = pend_q;

  // R5: every detected transition leaves its bit set next cycle
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((pending & $past(set_v)) == $past(set_v)));
  // R6: a clear with no coincident transition empties the bit
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_v & ~set_v) != '0) |=> ((pending & $past(clr_v & ~set_v)) == '0));
  // R6: bits neither set nor cleared hold their value
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v | clr_v) == '0) |=> $stable(pending));
endmodule

// File: rtl/pinio_edge_ctrl.sv
module pinio_edge_ctrl #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_word,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  import pinio_pkg::*;

  localparam logic [NLINES-1:0] ALL_ONES = '1;

  logic [NLINES-1:0] dir_q, out_q, en_q, wmask_q;
  logic [NLINES-1:0] lvl_w, edge_w, chg_w, clr_w;
  logic              wr_en;
  reg_idx_e          idx;

  assign idx   = reg_idx_e'(bus_word);
  assign wr_en = bus_sel & bus_wr;
  assign clr_w = (wr_en && idx == IDX_CHG) ? bus_wdata : '0;

  pinio_sync_edge #(.W(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .level(lvl_w), .toggled(edge_w)
  );

  pinio_change_latch #(.W(NLINES)) u_chg (
    .clk(clk), .rst_n(rst_n), .set_v(edge_w), .clr_v(clr_w), .pending(chg_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      en_q    <= '0;
      wmask_q <= ALL_ONES;
    end else if (wr_en) begin
      case (idx)
        IDX_DIR:   dir_q   <= bus_wdata;
        IDX_DATA:  out_q   <= NLINES'(masked_merge(32'(out_q), 32'(bus_wdata), 32'(wmask_q)));
        IDX_IRQEN: en_q    <= bus_wdata;
        IDX_WMASK: wmask_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_DIR:   bus_rdata = 32'(dir_q);
      IDX_DATA:  bus_rdata = pin_view(32'(out_q), 32'(lvl_w), 32'(dir_q));
      IDX_IRQEN: bus_rdata = 32'(en_q);
      IDX_CHG:   bus_rdata = 32'(chg_w);
      IDX_WMASK: bus_rdata = 32'(wmask_q);
      IDX_KIND:  bus_rdata = KIND_BOTH_EDGES;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(chg_w & en_q);

  // R3: output bits outside the write mask never move
  a_r3_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(wmask_q)) == '0));
  // R7: an interrupt needs an enabled line with a pending change
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en_q != '0) && (chg_w != '0)));
  // R9: nothing above the implemented lines is ever read back
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata >> NLINES) == 32'd0));
  // R8: the kind word is constant
  a_r8_kind_const: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_KIND) |-> (bus_rdata == 32'h1));
endmodule

// File: tb/test_pinio_edge_ctrl.sv
`timescale 1ns/1ps
module test_pinio_edge_ctrl;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_word = 3'd0;
  logic [N-1:0]  bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pinio_edge_ctrl #(.NLINES(N)) i_pinio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural reference model
  logic [N-1:0] m_dir, m_out, m_en, m_chg, m_mask;
  logic [N-1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin : model
    logic [N-1:0] ev, clr;
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_en = '0; m_chg = '0; m_mask = '1;
      hist = '{'0, '0, '0};
    end else begin
      ev  = hist[1] ^ hist[2];
      clr = '0;
      if (bus_sel && bus_wr) begin
        case (bus_word)
          3'd0: m_dir = bus_wdata;
          3'd1: for (int i = 0; i < N; i++) if (m_mask[i]) m_out[i] = bus_wdata[i];
          3'd2: m_en = bus_wdata;
          3'd3: clr = bus_wdata;
          3'd4: m_mask = bus_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < N; i++) begin
        if (ev[i]) m_chg[i] = 1'b1;
        else if (clr[i]) m_chg[i] = 1'b0;
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] w);
    logic [N-1:0] v;
    case (w)
      3'd0: return 32'(m_dir);
      3'd1: begin
        for (int i = 0; i < N; i++) v[i] = m_dir[i] ? m_out[i] : hist[1][i];
        return 32'(v);
      end
      3'd2: return 32'(m_en);
      3'd3: return 32'(m_chg);
      3'd4: return 32'(m_mask);
      3'd5: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 pin_oe", 32'(pin_oe), 32'(m_dir));
      chk("R3 pin_out", 32'(pin_out), 32'(m_out));
      chk("R7 irq", 32'(irq), 32'(|(m_chg & m_en)));
      chk("R2/R9 rdata", bus_rdata, m_read(bus_word));
    end
  end

  task automatic wr(logic [2:0] w, logic [N-1:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] w, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    bus_word = w;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(posedge clk); #1;
    pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset values
    rd(3'd0, 32'h0, "R9 dir reset");
    rd(3'd1, 32'h0, "R9 data reset");
    rd(3'd2, 32'h0, "R9 enable reset");
    rd(3'd3, 32'h0, "R9 change reset");
    rd(3'd4, 32'h0000_FFFF, "R3 mask reset");
    rd(3'd6, 32'h0, "R9 unmapped word");
    chk("R7 irq reset", 32'(irq), 32'h0);

    // R8: kind word ignores writes
    wr(3'd5, 16'h0000);
    rd(3'd5, 32'h1, "R8 kind constant");

    // R1: direction
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 32'h0000_FFFF, "R9 dir upper zero");
    wr(3'd0, 16'h00FF);
    @(negedge clk);
    chk("R1 pin_oe", 32'(pin_oe), 32'h0000_00FF);

    // R3: masked data writes
    wr(3'd1, 16'hA5A5);
    @(negedge clk);
    chk("R3 full write", 32'(pin_out), 32'h0000_A5A5);
    wr(3'd4, 16'h0F0F);
    wr(3'd1, 16'h0000);
    @(negedge clk);
    chk("R3 masked write", 32'(pin_out), 32'h0000_A0A0);
    wr(3'd4, 16'hFFFF);

    // R2/R5: input levels and rising edges
    set_pins(16'h1200);
    idle(4);
    rd(3'd1, 32'h0000_12A0, "R2 mixed read");
    rd(3'd3, 32'h0000_1200, "R5 rising sets");

    // R4/R7: enable and interrupt
    chk("R7 masked irq", 32'(irq), 32'h0);
    wr(3'd2, 16'h0200);
    rd(3'd2, 32'h0000_0200, "R4 enable readback");
    chk("R7 irq raised", 32'(irq), 32'h1);

    // R6: write-one-to-clear
    wr(3'd3, 16'h0200);
    rd(3'd3, 32'h0000_1000, "R6 w1c");
    chk("R7 irq dropped", 32'(irq), 32'h0);
    wr(3'd3, 16'h0000);
    rd(3'd3, 32'h0000_1000, "R6 zero no effect");

    // R5: falling edge
    wr(3'd3, 16'h1000);
    rd(3'd3, 32'h0, "R6 cleared");
    set_pins(16'h0200);
    idle(4);
    rd(3'd3, 32'h0000_1000, "R5 falling sets");

    // R6: edge coincides with clear -> set wins
    @(posedge clk); #1;
    pin_in = 16'h1200;
    @(posedge clk);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 3'd3; bus_wdata = 16'h1000;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(3'd3, 32'h0000_1000, "R6 collision keeps bit");

    // R5: output pin direction irrelevant, several patterns
    wr(3'd3, 16'hFFFF);
    set_pins(16'h0003);
    idle(4);
    rd(3'd3, 32'h0000_1203, "R5 multi-bit");
    wr(3'd2, 16'h0001);
    chk("R7 enabled bit0", 32'(irq), 32'h1);

    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule